// File: doc/BRIEF.md
# Video Frame Capture Writer

This block stores a live digital video stream in an external static RAM, one word per pixel. It receives a pixel clock, a horizontal and a vertical sync, a data-enable that marks active pixels, and a 15-bit RGB word holding 5 bits each of red, green and blue. It keeps no copy of the sync timing. Two counters follow the raster, and their values form the RAM address. The place where a pixel is written is therefore the only record of its position in the frame.

A rising edge on vertical sync clears the counters and arms capture, but only while `capture_en` is high. The first rising edge on horizontal sync after that opens line 0. Each later horizontal edge starts the next line. Every active pixel inside the window is written in the cycle that follows its arrival, so the block keeps up with one pixel per clock. The RAM strobes are active low. The data bus is driven only during a write and is released at all other times. When the next vertical edge closes a frame in which at least one pixel was written, a single-cycle pulse is raised and a sticky flag reports that a complete frame is in the RAM.

Top module: `vidcap_sram_writer`

## Requirements
- R1: A written word carries bit 15 as 0 and the RGB input in bits 14..0. The address is {line, column}, with the line in bits 18..10 and the column in bits 9..0.
- R2: A pixel at column MAX_COLS (default 640) or beyond, or at line MAX_LINES (default 480) or beyond, is not written. Neither counter wraps round.
- R3: `sram_dq` is driven only in cycles where `sram_we_n` is 0 and is high impedance otherwise. `sram_cs_n` is 0 exactly in write cycles. `sram_oe_n` stays 1.
- R4: A pixel whose `pix_de` is sampled high at clock edge k, while capture is open and the pixel is in the window, shows `sram_we_n` low for exactly the cycle after edge k. Back-to-back pixels give back-to-back writes.
- R5: A rising edge of `vsync` clears the line and column counters and closes capture. If `capture_en` is high in that cycle, capture is armed. Capture opens at the next rising edge of `hsync`, which starts line 0, column 0. Pixels that arrive before that edge are not written.
- R6: Each later rising edge of `hsync` sets the column to 0 and advances the line. No pixel is written in a cycle that holds an `hsync` or `vsync` rising edge.
- R7: `frame_done` is a one-cycle pulse. It follows a `vsync` rising edge only when capture was open and at least one pixel had been written since it opened. `frame_stored` rises together with that pulse and clears when the next capture opens.
- R8: If `capture_en` is low at the `vsync` rising edge, nothing is written until a later `vsync` edge arms capture.
- R9: After reset, `sram_we_n`, `sram_cs_n` and `sram_oe_n` are 1, `sram_dq` is high impedance, and `frame_done` and `frame_stored` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| capture_en | input | 1 | Allows the next vertical edge to arm capture |
| vsync | input | 1 | Vertical sync, active high, rising edge used |
| hsync | input | 1 | Horizontal sync, active high, rising edge used |
| pix_de | input | 1 | Marks the current pixel as active |
| pix_rgb | input | 15 | Pixel colour, red in 14..10, green in 9..5, blue in 4..0 |
| sram_addr | output | 19 | RAM address {line, column} |
| sram_dq | inout | 16 | RAM data bus, driven only while writing |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, held deasserted |
| sram_cs_n | output | 1 | RAM chip select, active low |
| frame_done | output | 1 | One-cycle pulse when a frame completes |
| frame_stored | output | 1 | A complete frame is held in the RAM |

## Verification
The line limit is the hardest case to reach from the ports, because a full-width frame would need more than 300,000 pixel clocks. The bench therefore sends 485 very short lines of two pixels each, which pushes the line counter past its limit in a few thousand cycles. One 660-pixel line covers the column limit. Arming matters in both directions, so pixels are also sent before the first horizontal edge, before any vertical edge at all, and through a frame whose vertical edge saw `capture_en` low.

// File: rtl/vidcap_pkg.sv
package vidcap_pkg;

    localparam int COL_W  = 10;
    localparam int LINE_W = 9;
    localparam int PIX_W  = 15;
    localparam int ADDR_W = LINE_W + COL_W;
    localparam int DQ_W   = PIX_W + 1;

    // raster tracking state
    typedef struct packed {
        logic              armed;
        logic              capturing;
        logic              wrote;
        logic              stored;
        logic [LINE_W-1:0] line;
        logic [COL_W-1:0]  col;
    } raster_t;

    // registered RAM-side outputs
    typedef struct packed {
        logic              we_n;
        logic              cs_n;
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic [DQ_W-1:0]   data;
    } wport_t;

endpackage

// File: rtl/vidcap_edge.sv
module vidcap_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign rise[i] = level[i] & ~prev_q[i];
    end

endmodule

// File: rtl/vidcap_raster.sv
module vidcap_raster
    import vidcap_pkg::*;
#(
    parameter int MAX_COLS  = 640,
    parameter int MAX_LINES = 480
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic              vs_rise,
    input  logic              hs_rise,
    input  logic              pix_de,
    input  logic [PIX_W-1:0]  pix_rgb,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DQ_W-1:0]   wr_data,
    output logic              done_evt,
    output logic              stored
);

    localparam logic [COL_W-1:0]  COL_LIMIT  = COL_W'(MAX_COLS);
    localparam logic [LINE_W-1:0] LINE_LIMIT = LINE_W'(MAX_LINES);

    raster_t r_d, r_q;
    logic    in_window;

    assign in_window = (r_q.col < COL_LIMIT) && (r_q.line < LINE_LIMIT);

    always_comb begin
        r_d      = r_q;
        wr_req   = 1'b0;
        done_evt = 1'b0;
        if (vs_rise) begin
            done_evt    = r_q.capturing && r_q.wrote;
            if (done_evt) r_d.stored = 1'b1;
            r_d.line      = '0;
            r_d.col       = '0;
            r_d.capturing = 1'b0;
            r_d.armed     = capture_en;
            r_d.wrote     = 1'b0;
        end else if (hs_rise) begin
            if (r_q.armed) begin
                r_d.armed     = 1'b0;
                r_d.capturing = 1'b1;
                r_d.stored    = 1'b0;
                r_d.line      = '0;
                r_d.col       = '0;
            end else if (r_q.capturing) begin
                if (r_q.line < LINE_LIMIT) r_d.line = r_q.line + 1'b1;
                r_d.col = '0;
            end
        end else if (r_q.capturing && pix_de && in_window) begin
            wr_req    = 1'b1;
            r_d.col   = r_q.col + 1'b1;
            r_d.wrote = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign wr_addr = {r_q.line, r_q.col};
    assign wr_data = {1'b0, pix_rgb};
    assign stored  = r_q.stored;

endmodule

// File: rtl/vidcap_sram_port.sv
module vidcap_sram_port
    import vidcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DQ_W-1:0]   wr_data,
    input  logic              done_evt,
    output logic [ADDR_W-1:0] sram_addr,
    inout  wire  [DQ_W-1:0]   sram_dq,
    output logic              sram_we_n,
    output logic              sram_cs_n,
    output logic              frame_done
);

    wport_t p_d, p_q;

    always_comb begin
        p_d      = p_q;
        p_d.we_n = ~wr_req;
        p_d.cs_n = ~wr_req;
        p_d.done = done_evt;
        if (wr_req) begin
            p_d.addr = wr_addr;
            p_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q      <= '0;
            p_q.we_n <= 1'b1;
            p_q.cs_n <= 1'b1;
        end else begin
            p_q <= p_d;
        end
    end

    assign sram_addr  = p_q.addr;
    assign sram_we_n  = p_q.we_n;
    assign sram_cs_n  = p_q.cs_n;
    assign frame_done = p_q.done;
    assign sram_dq    = p_q.we_n ? {DQ_W{1'bz}} : p_q.data;

endmodule

// File: rtl/vidcap_sram_writer.sv
module vidcap_sram_writer
    import vidcap_pkg::*;
#(
    parameter int MAX_COLS  = 640,
    parameter int MAX_LINES = 480
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic              vsync,
    input  logic              hsync,
    input  logic              pix_de,
    input  logic [PIX_W-1:0]  pix_rgb,
    output logic [ADDR_W-1:0] sram_addr,
    inout  wire  [DQ_W-1:0]   sram_dq,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic              sram_cs_n,
    output logic              frame_done,
    output logic              frame_stored
);

    logic [1:0]        rises;
    logic              wr_req, done_evt;
    logic [ADDR_W-1:0] wr_addr;
    logic [DQ_W-1:0]   wr_data;

    vidcap_edge #(.N(2)) i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level ({vsync, hsync}),
        .rise  (rises)
    );

    vidcap_raster #(.MAX_COLS(MAX_COLS), .MAX_LINES(MAX_LINES)) i_raster (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .vs_rise    (rises[1]),
        .hs_rise    (rises[0]),
        .pix_de     (pix_de),
        .pix_rgb    (pix_rgb),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .done_evt   (done_evt),
        .stored     (frame_stored)
    );

    vidcap_sram_port i_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .done_evt   (done_evt),
        .sram_addr  (sram_addr),
        .sram_dq    (sram_dq),
        .sram_we_n  (sram_we_n),
        .sram_cs_n  (sram_cs_n),
        .frame_done (frame_done)
    );

    // read path never used during capture
    assign sram_oe_n = 1'b1;

endmodule

// File: rtl/vidcap_sram_writer_chk.sv
module vidcap_sram_writer_chk #(
    parameter int MAX_COLS  = 640,
    parameter int MAX_LINES = 480
) (
    input logic        clk,
    input logic        rst_n,
    input logic        vsync,
    input logic [18:0] sram_addr,
    input wire  [15:0] sram_dq,
    input logic        sram_we_n,
    input logic        frame_done,
    input logic        frame_stored
);

    a_r1_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_dq[15] == 1'b0));

    a_r2_addr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> ((32'(sram_addr[9:0]) < MAX_COLS) && (32'(sram_addr[18:10]) < MAX_LINES)));

    a_r6_column_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && !$past(sram_we_n) && (sram_addr[18:10] == $past(sram_addr[18:10])))
        |-> ((sram_addr[9:0] - $past(sram_addr[9:0])) == 10'd1));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    a_r7_done_after_vsync: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(vsync));

    a_r7_stored_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_stored) |-> frame_done);

endmodule

bind vidcap_sram_writer vidcap_sram_writer_chk #(
    .MAX_COLS  (MAX_COLS),
    .MAX_LINES (MAX_LINES)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vsync        (vsync),
    .sram_addr    (sram_addr),
    .sram_dq      (sram_dq),
    .sram_we_n    (sram_we_n),
    .frame_done   (frame_done),
    .frame_stored (frame_stored)
);

// File: tb/test_vidcap_sram_writer.sv
`timescale 1ns/1ps
module test_vidcap_sram_writer;

    localparam int NCOL = 640;
    localparam int NLIN = 480;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        capture_en = 1'b0, vsync = 1'b0, hsync = 1'b0, pix_de = 1'b0;
    logic [14:0] pix_rgb = '0;
    logic [18:0] sram_addr;
    wire  [15:0] sram_dq;
    logic        sram_we_n, sram_oe_n, sram_cs_n, frame_done, frame_stored;

    int errors = 0, checks = 0, done_count = 0, write_count = 0;
    bit live = 1'b0;

    always #10 clk = ~clk;

    vidcap_sram_writer i_vidcap_sram_writer (
        .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .vsync(vsync),
        .hsync(hsync), .pix_de(pix_de), .pix_rgb(pix_rgb), .sram_addr(sram_addr),
        .sram_dq(sram_dq), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_cs_n(sram_cs_n), .frame_done(frame_done), .frame_stored(frame_stored)
    );

    // behavioural reference
    int  m_line, m_col;
    bit  m_armed, m_cap, m_wrote, m_stored, m_phs, m_pvs;
    bit  e_write, e_done;
    int  e_addr, e_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_line = 0; m_col = 0; m_armed = 0; m_cap = 0; m_wrote = 0;
            m_stored = 0; m_phs = 0; m_pvs = 0; e_write = 0; e_done = 0;
        end else begin
            bit hr, vr;
            hr = hsync && !m_phs;
            vr = vsync && !m_pvs;
            m_phs = hsync; m_pvs = vsync;
            e_write = 0; e_done = 0;
            if (vr) begin
                if (m_cap && m_wrote) begin e_done = 1; m_stored = 1; end
                m_line = 0; m_col = 0; m_cap = 0; m_wrote = 0; m_armed = capture_en;
            end else if (hr) begin
                if (m_armed) begin
                    m_armed = 0; m_cap = 1; m_line = 0; m_col = 0; m_stored = 0;
                end else if (m_cap) begin
                    if (m_line < NLIN) m_line++;
                    m_col = 0;
                end
            end else if (m_cap && pix_de && m_col < NCOL && m_line < NLIN) begin
                e_write = 1;
                e_addr  = m_line * 1024 + m_col;
                e_data  = int'(pix_rgb);
                m_col++;
                m_wrote = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (live) begin
            chk(sram_we_n == !e_write, "R4", "we_n", int'(sram_we_n), int'(!e_write));
            chk(sram_cs_n == !e_write, "R3", "cs_n", int'(sram_cs_n), int'(!e_write));
            chk(sram_oe_n == 1'b1, "R3", "oe_n", int'(sram_oe_n), 1);
            if (e_write) begin
                write_count++;
                chk(int'(sram_addr) == e_addr, "R1", "addr", int'(sram_addr), e_addr);
                chk(sram_dq === 16'(e_data), "R1", "data", int'(sram_dq), e_data);
            end else begin
                chk(sram_dq === 16'bz, "R3", "dq released", int'(sram_dq), 0);
            end
            chk(frame_done == e_done, "R7", "frame_done", int'(frame_done), int'(e_done));
            chk(frame_stored == m_stored, "R7", "frame_stored", int'(frame_stored), int'(m_stored));
            if (frame_done) done_count++;
        end
    end

    task automatic cyc(input bit vs, input bit hs, input bit de);
        @(negedge clk);
        #1;
        vsync = vs; hsync = hs; pix_de = de;
        pix_rgb = pix_rgb * 15'd13 + 15'd7;
    endtask

    task automatic vpulse(input bit en);
        cyc(0, 0, 0); capture_en = en; cyc(1, 0, 0); cyc(1, 0, 0); cyc(0, 0, 0);
    endtask

    task automatic hpulse();
        cyc(0, 0, 0); cyc(0, 1, 0); cyc(0, 0, 0);
    endtask

    task automatic pixels(input int n, input bit gaps);
        for (int i = 0; i < n; i++) cyc(0, 0, gaps ? (i % 3 != 1) : 1'b1);
        cyc(0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk(sram_we_n && sram_cs_n && sram_oe_n, "R9", "strobes", int'({sram_we_n, sram_cs_n, sram_oe_n}), 7);
        chk(sram_dq === 16'bz, "R9", "dq", int'(sram_dq), 0);
        chk(!frame_done && !frame_stored, "R9", "flags", int'({frame_done, frame_stored}), 0);
        rst_n = 1'b1;
        live = 1'b1;

        // R5: nothing written before any vertical edge
        hpulse(); pixels(6, 0);
        // frame 1: pixels before first hsync are dropped (R5), gapped line (R4, R6)
        vpulse(1); pixels(4, 0);
        hpulse(); pixels(9, 1);
        hpulse(); pixels(5, 0);
        // hsync and de together: no write in edge cycle (R6)
        cyc(0, 1, 1); cyc(0, 0, 1); cyc(0, 0, 1); cyc(0, 0, 0);
        vpulse(0); // R7 done here; R8 next frame disarmed
        chk(done_count == 1, "R7", "done count frame1", done_count, 1);
        hpulse(); pixels(7, 0); hpulse(); pixels(3, 0);
        vpulse(1);
        chk(done_count == 1, "R8", "no done for disarmed frame", done_count, 1);
        // frame 3: column limit then line limit (R2)
        hpulse(); pixels(NCOL + 20, 0);
        for (int l = 0; l < NLIN + 5; l++) begin hpulse(); pixels(2, 0); end
        // vsync during same cycle as de (R6)
        cyc(0, 0, 1); capture_en = 1'b1; cyc(1, 0, 1); cyc(1, 0, 1); cyc(0, 0, 0);
        chk(done_count == 2, "R7", "done count frame3", done_count, 2);
        // empty frame: armed, opened, nothing written -> no done (R7)
        hpulse(); vpulse(1);
        chk(done_count == 2, "R7", "no done for empty frame", done_count, 2);
        chk(write_count > NCOL, "R2", "write volume", write_count, NCOL);
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule